// File: doc/BRIEF.md
# I2C Register-Read Slave

This block is an I2C slave that serves reads only. A host reads eight 16-bit registers one byte at a time. The register values arrive on a flat parallel bus. The single address byte carries three things: a 3-bit chip identity compared with strap pins, a 4-bit byte index into the sixteen register bytes, and the direction flag. Because of this, a read needs no earlier pointer-write phase.

SCL and SDA pass through two-flop synchronisers clocked by a system clock at least eight times the SCL rate. Start and stop conditions, the address byte and the master's acknowledge are all decoded from the synchronised lines. The slave drives SDA only through an open-drain enable: a 1 on that output pulls the line low. While the master keeps acknowledging, the byte index advances. When the master does not acknowledge, the slave falls silent.

Top module: `i2c_regrd_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and stays 0 until a matching address byte has been received.
- R2: The address byte is sent MSB first as bits 7..5 = chip identity, bits 4..1 = byte index, bit 0 = direction, where 1 means read. When bits 7..5 equal `strap_i` and bit 0 is 1, the slave pulls SDA low for the whole high phase of the ninth SCL pulse.
- R3: When bits 7..5 differ from `strap_i`, the slave never pulls SDA low at any point until the next start condition.
- R4: An address byte whose direction bit is 0 is not acknowledged, and nothing is driven until the next start condition.
- R5: Byte index k selects register k>>1. Even k gives bits 7..0 and odd k gives bits 15..8. Each byte is driven MSB first, one bit per SCL pulse, with the enable equal to the inverse of the data bit.
- R6: A byte that the master acknowledges (SDA low on the ninth pulse) is followed by the byte at index k+1. After index 15 the index wraps to 0.
- R7: Within a continued read, a high byte that follows its low byte is taken from the 16-bit value captured when the low byte was loaded, even if the input bus has changed since.
- R8: After a not-acknowledge (SDA high on the ninth pulse), the slave releases SDA and drives nothing until the next start condition.
- R9: A stop condition (SDA rising while SCL is high) returns the slave to idle from any phase, including the middle of an address byte.
- R10: A start condition (SDA falling while SCL is high), including a repeated start inside a transfer, drops the current transfer and begins a fresh address byte.
- R11: The pull-down enable changes only while the synchronised SCL is low, and it holds steady through every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus (wired value) |
| strap_i | input | 3 | Chip identity strap pins |
| reg_bus_i | input | 128 | Register values, register n at bits 16n+15..16n |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench runs a continued read that crosses index 15, so a design that saturated the index or skipped the wrap would return the wrong second byte. It changes every register value while a low byte is being shifted out. A design that reread the live bus for the high byte would then return bytes from two different register values. It sends a stop and a repeated start in the middle of an address byte, a mismatched chip identity and a write-direction byte, and checks that a design which miscounted bits or ignored the abort would acknowledge or drive at the wrong time. After a not-acknowledge it keeps clocking SCL, which exposes a slave that keeps shifting data.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TX,
        ST_RACK
    } rd_state_e;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Bus lines idle high, so both stages reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_o <= '1;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/i2c_rd_bytesel.sv
module i2c_rd_bytesel #(
    parameter int NREG = 8,
    parameter int RW   = 16,
    localparam int IDXW = $clog2(NREG) + 1
) (
    input  logic [NREG*RW-1:0] regs_i,
    input  logic [IDXW-1:0]    idx_i,
    input  logic [RW-1:0]      hold_i,
    input  logic               use_hold_i,
    output logic [RW-1:0]      word_o,
    output logic [7:0]         byte_o
);
    logic [IDXW-2:0] reg_sel;

    assign reg_sel = idx_i[IDXW-1:1];
    assign word_o  = regs_i[reg_sel*RW +: RW];

    always_comb begin
        if (idx_i[0])
            byte_o = use_hold_i ? hold_i[15:8] : word_o[15:8];
        else
            byte_o = word_o[7:0];
    end
endmodule

// File: rtl/i2c_regrd_slave.sv
module i2c_regrd_slave
    import i2c_rd_pkg::*;
#(
    parameter int NREG = 8,
    parameter int RW   = 16,
    localparam int IDXW  = $clog2(NREG) + 1,
    localparam int CHIPW = 8 - 1 - IDXW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [CHIPW-1:0]   strap_i,
    input  logic [NREG*RW-1:0] reg_bus_i,
    output logic               sda_oe_o
);
    typedef struct packed {
        rd_state_e       st;
        logic [7:0]      sh;
        logic [3:0]      cnt;
        logic [IDXW-1:0] idx;
        logic [RW-1:0]   hold;
        logic            oe;
        logic            ack;
        logic            scl_p;
        logic            sda_p;
    } ctx_t;

    ctx_t q, d;
    logic scl_s, sda_s;
    logic start_det, stop_det, scl_rise, scl_fall, addr_hit;
    logic [IDXW-1:0] sel_idx;
    logic [RW-1:0]   sel_word;
    logic [7:0]      sel_byte;

    i2c_rd_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({scl_i, sda_i}),
        .sync_o ({scl_s, sda_s})
    );

    // A continued read fetches index+1; the first byte fetches the address index.
    assign sel_idx = (q.st == ST_RACK) ? q.idx + 1'b1 : q.idx;

    i2c_rd_bytesel #(.NREG(NREG), .RW(RW)) u_sel (
        .regs_i    (reg_bus_i),
        .idx_i     (sel_idx),
        .hold_i    (q.hold),
        .use_hold_i(q.st == ST_RACK),
        .word_o    (sel_word),
        .byte_o    (sel_byte)
    );

    assign start_det = q.scl_p & scl_s & q.sda_p & ~sda_s;
    assign stop_det  = q.scl_p & scl_s & ~q.sda_p & sda_s;
    assign scl_rise  = ~q.scl_p & scl_s;
    assign scl_fall  = q.scl_p & ~scl_s;
    assign addr_hit  = (q.sh[7:8-CHIPW] == strap_i) & q.sh[0];

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        unique case (q.st)
            ST_IDLE: ;
            ST_ADDR: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end
                if (scl_fall && q.cnt == 4'd8) begin
                    if (addr_hit) begin
                        d.st  = ST_AACK;
                        d.oe  = 1'b1;
                        d.idx = q.sh[IDXW:1];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (q.cnt == 4'd7) begin
                        d.st = ST_RACK;
                        d.oe = 1'b0;
                    end else begin
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.oe  = ~q.sh[6];
                        d.cnt = q.cnt + 4'd1;
                    end
                end
            end
            ST_AACK, ST_RACK: begin
                if (scl_rise)
                    d.ack = ~sda_s;
                if (scl_fall) begin
                    if (q.st == ST_AACK || q.ack) begin
                        d.idx = sel_idx;
                        d.sh  = sel_byte;
                        d.cnt = 4'd0;
                        d.st  = ST_TX;
                        d.oe  = ~sel_byte[7];
                        if (!sel_idx[0])
                            d.hold = sel_word;
                    end else begin
                        d.st = ST_IDLE;
                        d.oe = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !$past(scl_s)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe); // R8
    AST_ACK_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AACK) |-> (q.sh[7:8-CHIPW] == strap_i)); // R3
    AST_ACK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AACK) |-> q.sh[0]); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RACK && scl_fall && q.ack && !start_det && !stop_det)
        |=> (q.idx == $past(q.idx) + 1'b1)); // R6
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (q.st == ST_IDLE)); // R9
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR)); // R10
endmodule

// File: tb/i2c_regrd_slave_bench.sv
module i2c_regrd_slave_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_m = 1'b0;
    logic [2:0]   strap = 3'd5;
    logic [15:0]  rv [8];
    logic [127:0] reg_bus;
    logic         sda_oe;
    logic         sda_bus;

    int    vec = 0;
    int    err = 0;
    bit    chk_on = 1'b0;
    bit    exp_oe = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    logic [15:0] hold_m;

    always #10 clk = ~clk;

    always_comb
        for (int k = 0; k < 8; k++) reg_bus[k*16 +: 16] = rv[k];

    assign sda_bus = ~(sda_m | sda_oe);

    i2c_regrd_slave u_i2c_regrd_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .reg_bus_i(reg_bus),
        .sda_oe_o (sda_oe)
    );

    // Reference comparison every clock of every SCL high phase; a steady
    // expected value across the phase also covers R11.
    always @(negedge clk) begin
        if (chk_on) begin
            vec++;
            if (sda_oe !== exp_oe) begin
                err++;
                $display("FAIL %s t=%0t oe=%b expected %b", tag, $time, sda_oe, exp_oe);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bitc(input bit mlow, input bit e);
        sda_m  = mlow;
        exp_oe = e;
        tick(4);
        scl    = 1'b1;
        chk_on = 1'b1;
        tick(8);
        chk_on = 1'b0;
        scl    = 1'b0;
        tick(4);
    endtask

    task automatic do_start();
        sda_m = 1'b0;
        tick(4);
        scl = 1'b1;
        tick(4);
        sda_m = 1'b1;
        tick(4);
        scl = 1'b0;
        tick(4);
    endtask

    task automatic do_stop();
        sda_m = 1'b1;
        tick(4);
        scl = 1'b1;
        tick(4);
        sda_m = 1'b0;
        tick(8);
    endtask

    task automatic idle_bits(input int n, input string t);
        tag = t;
        for (int i = 0; i < n; i++) bitc(1'b0, 1'b0);
    endtask

    task automatic send_addr(input logic [7:0] a, input bit ack_exp, input string t);
        tag = t;
        for (int i = 7; i >= 0; i--) bitc(~a[i], 1'b0);
        bitc(1'b0, ack_exp);
    endtask

    // Full read: start, address byte, nb data bytes, NACK on the last, stop.
    task automatic rd(input logic [2:0] chip, input logic [3:0] idx, input int nb,
                      input bit rw, input bit bump, input string t);
        logic [3:0] k;
        logic [7:0] val;
        bit         ack;
        ack = (chip == strap) && rw;
        do_start();
        send_addr({chip, idx, rw}, ack, ack ? "R2" : t);
        if (!ack) begin
            idle_bits(9, t);
            do_stop();
            return;
        end
        k = idx;
        for (int j = 0; j < nb; j++) begin
            if (j > 0) k = k + 4'd1;
            if (!k[0]) begin
                hold_m = rv[k[3:1]];
                val    = hold_m[7:0];
            end else begin
                val = (j == 0) ? rv[k[3:1]][15:8] : hold_m[15:8];
            end
            tag = t;
            for (int b = 7; b >= 0; b--) begin
                bitc(1'b0, ~val[b]);
                if (bump && j == 0 && b == 7)
                    for (int r = 0; r < 8; r++) rv[r] = rv[r] ^ 16'hA5A5;
            end
            tag = (j == nb - 1) ? "R8" : "R6";
            bitc(j != nb - 1, 1'b0);
        end
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) rv[r] = 16'h1000 * (r + 1) + 16'h0101 * (r * 3 + 2);
        tick(5);
        vec++;
        if (sda_oe !== 1'b0) begin
            err++;
            $display("FAIL R1 oe=%b expected 0 in reset", sda_oe);
        end
        rst_n = 1'b1;
        tick(4);
        idle_bits(3, "R1");

        rd(3'd5, 4'd0, 3, 1'b1, 1'b0, "R5");   // R5 R6 low/high/low, MSB first
        rd(3'd5, 4'd15, 2, 1'b1, 1'b0, "R6");  // R6 wrap 15 -> 0
        rd(3'd5, 4'd3, 1, 1'b1, 1'b0, "R5");   // R5 odd index first
        rd(3'd5, 4'd10, 4, 1'b1, 1'b0, "R5");
        rd(3'd2, 4'd0, 1, 1'b1, 1'b0, "R3");   // R3 chip mismatch
        rd(3'd5, 4'd0, 1, 1'b0, 1'b0, "R4");   // R4 write direction
        rd(3'd5, 4'd4, 2, 1'b1, 1'b1, "R7");   // R7 bus changes mid-pair

        // R8: after NACK keep clocking; nothing may be driven.
        rd(3'd5, 4'd7, 1, 1'b1, 1'b0, "R8");
        do_start();
        send_addr({3'd5, 4'd6, 1'b1}, 1'b1, "R2");
        tag = "R8";
        for (int b = 7; b >= 0; b--) bitc(1'b0, ~rv[3][7 - 7 + b]);
        bitc(1'b0, 1'b0);
        idle_bits(9, "R8");
        do_stop();

        // R9: stop in the middle of an address byte.
        do_start();
        tag = "R9";
        bitc(1'b0, 1'b0); bitc(1'b1, 1'b0); bitc(1'b0, 1'b0);
        do_stop();
        idle_bits(9, "R9");
        rd(3'd5, 4'd9, 1, 1'b1, 1'b0, "R9");

        // R10: repeated start in the middle of an address byte.
        do_start();
        tag = "R10";
        bitc(1'b0, 1'b0); bitc(1'b0, 1'b0); bitc(1'b1, 1'b0);
        rd(3'd5, 4'd12, 2, 1'b1, 1'b0, "R10");

        strap = 3'd2;
        tick(4);
        rd(3'd2, 4'd1, 2, 1'b1, 1'b0, "R2");
        rd(3'd5, 4'd1, 1, 1'b1, 1'b0, "R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule